// File: doc/BRIEF.md
# Half-Bridge Fault Protection Controller

This block sits between a latched command register and six half-bridge power stages. Each stage has a low-side and a high-side switch. The block decides which of the twelve switch enables may be driven. It applies a per-stage short-circuit shutdown timer, a supply-undervoltage timer, a thermal shutdown latch and two inhibit sources. It also prevents cross-conduction within each stage and builds a 16-bit status word for the host.

The analog comparators are modelled as level flags at the inputs. Every delay is counted in periods of a slow `tick` strobe, which stands in for an on-chip low-frequency oscillator.

The command word is captured on `cmd_wr`. Its bit layout is as follows:
- Bit 0 is a one-shot "clear latched faults" request.
- Bits 1..12 are the switch requests. Bit 2k+1 is the low side of stage k, and bit 2k+2 is its high side.
- Bit 13 low enables open-load reporting.
- Bit 14 selects the long short-circuit delay.
- Bit 15 is the run (software enable) bit.

The status word is laid out as follows:
- Bit 0 is the thermal prewarning.
- Bits 1..12 are the per-switch states, in the same positions as the command bits.
- Bit 13 is the short-circuit flag.
- Bit 14 is the inhibit indication.
- Bit 15 is the supply-fail flag.

Top module: `hb_fault_ctrl`

## Requirements
- R1: After reset the stored command is run=1, long delay=1, open-load reporting off, and every switch request and the clear bit are 0. `sw_en` and `status` read 0 while `tp_flag` is low, whatever `ol_flag` shows.
- R2: With no fault or inhibit, the driven enable follows the stored request. Enable index 2k is the low side of stage k, and index 2k+1 is its high side. Status bit j+1 shows enable j. An enable changes on the second rising edge after the write.
- R3: A stage whose two switches are both requested drives neither of them.
- R4: After one switch of a stage turns off, its partner stays off until `DEAD_TICKS` ticks have passed. Turning the same switch back on needs no wait.
- R5: An overcurrent flag held for the selected delay turns off both switches of that stage only, and sets status bit 13. The delay is `SC_LONG_TICKS` when command bit 14 is 1 and `SC_SHORT_TICKS` when it is 0.
- R6: When an overcurrent flag drops before its delay expires, that stage's timer restarts from zero.
- R7: An undervoltage held for `UV_TICKS` ticks turns off all switches and sets status bit 15. The switches return as soon as the undervoltage clears. Bit 15 stays set until a clear command.
- R8: The thermal shutdown flag turns off all switches and forces all 16 status bits to 1. Recovery needs the flag low and then a write with bit 0 = 1. A clear written while the flag is still high has no effect.
- R9: Status bit 0 equals `tp_flag` at all times outside thermal shutdown.
- R10: A write with bit 0 = 1 clears status bits 13 and 15 and the thermal shutdown state. It also turns stages shut down by a short back on.
- R11: Command bit 15 = 0 or `inh_n` = 0 turns all switches off and sets status bit 14. Commands are still accepted during inhibit.
- R12: With command bit 13 = 0, the status bit of each switch that is not requested shows its `ol_flag` bit. A requested switch shows its on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe that paces all delays |
| cmd_in | input | 16 | Command word |
| cmd_wr | input | 1 | Capture strobe for `cmd_in` |
| oc_flag | input | 6 | Per-stage overcurrent flags |
| uv_flag | input | 1 | Supply undervoltage flag |
| tp_flag | input | 1 | Thermal prewarning flag |
| tsd_flag | input | 1 | Thermal shutdown flag |
| ol_flag | input | 12 | Per-switch open-load comparator flags |
| inh_n | input | 1 | Inhibit pin, low = all switches off |
| sw_en | output | 12 | Gated switch enables |
| status | output | 16 | Status word |

## Verification
The bench builds the block with short delays: `SC_SHORT_TICKS`=3, `SC_LONG_TICKS`=8, `UV_TICKS`=5 and `DEAD_TICKS`=2. The tick arrives every fourth clock. With these values, every delay boundary is checked on both sides within one tick in a few dozen cycles. Both short-circuit delay selections and the timer restart can be exercised repeatedly. The short delays also leave room to sweep every single switch and every four-state combination of the stage requests.

// File: rtl/hb_pkg.sv
package hb_pkg;
    // Command bit 0 requests a clear of latched faults; status bit 0 is prewarning.
    localparam int POS_CLEAR   = 0;
    localparam int POS_PREWARN = 0;
    // Switch requests and switch states start at bit 1, two bits per stage.
    localparam int SW_BASE     = 1;
    // Control and status fields placed directly above the switch field.
    localparam int OFS_OLOFF   = 0;  // command: open-load reporting off
    localparam int OFS_LONG    = 1;  // command: long short-circuit delay
    localparam int OFS_RUN     = 2;  // command: software enable
    localparam int OFS_SCD     = 0;  // status: short-circuit flag
    localparam int OFS_INH     = 1;  // status: inhibit active
    localparam int OFS_PSF     = 2;  // status: supply fail flag

    typedef enum logic {SIDE_LOW = 1'b0, SIDE_HIGH = 1'b1} side_e;

    function automatic int top_bit(input int n_leg, input int ofs);
        return SW_BASE + 2 * n_leg + ofs;
    endfunction
endpackage

// File: rtl/hb_delay_timer.sv
module hb_delay_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             done,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             flag;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run)
            st_d.cnt = '0;
        else if (tick && (st_q.cnt < limit))
            st_d.cnt = st_q.cnt + 1'b1;
        st_d.done = run && (st_q.cnt >= limit);
        st_d.flag = (st_q.flag && !clr) || st_d.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign flag = st_q.flag;

    // R5 / R7: a latched flag only rises after the condition was present
    p_flag_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(run));
    // R6: dropping the condition restarts the count
    p_count_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));
    // R7 / R10: the latched flag holds until a clear request
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr) |=> st_q.flag);
endmodule

// File: rtl/hb_leg_gate.sv
module hb_leg_gate
    import hb_pkg::*;
#(
    parameter int DEAD_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req_lo,
    input  logic req_hi,
    output logic en_lo,
    output logic en_hi
);
    localparam int DW = $clog2(DEAD_TICKS + 2);
    localparam logic [DW-1:0] GAP = DW'(DEAD_TICKS);

    typedef struct packed {
        logic          lo;
        logic          hi;
        side_e         last;
        logic [DW-1:0] gap;
    } leg_t;

    leg_t st_d, st_q;
    logic want_lo, want_hi, gap_ok;

    always_comb begin
        st_d    = st_q;
        want_lo = req_lo && !req_hi;
        want_hi = req_hi && !req_lo;
        gap_ok  = (st_q.gap == GAP);
        if (st_q.lo) begin
            st_d.lo = want_lo;
        end else if (st_q.hi) begin
            st_d.hi = want_hi;
        end else begin
            st_d.lo = want_lo && (gap_ok || st_q.last == SIDE_LOW);
            st_d.hi = want_hi && (gap_ok || st_q.last == SIDE_HIGH);
        end
        if (st_q.lo || st_q.hi)
            st_d.gap = '0;
        else if (tick && !gap_ok)
            st_d.gap = st_q.gap + 1'b1;
        if (st_q.hi)      st_d.last = SIDE_HIGH;
        else if (st_q.lo) st_d.last = SIDE_LOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lo: 1'b0, hi: 1'b0, last: SIDE_LOW, gap: GAP};
        else        st_q <= st_d;
    end

    assign en_lo = st_q.lo;
    assign en_hi = st_q.hi;

    // R3: the two switches of one stage are never on together
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.lo && st_q.hi));

    if (DEAD_TICKS > 0) begin : g_gap_chk
        // R4: the partner never follows in the next cycle
        p_gap_after_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.hi) |=> !st_q.lo);
        p_gap_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.lo) |=> !st_q.hi);
    end
endmodule

// File: rtl/hb_fault_ctrl.sv
module hb_fault_ctrl
    import hb_pkg::*;
#(
    parameter int N_LEG          = 6,
    parameter int SC_SHORT_TICKS = 48,
    parameter int SC_LONG_TICKS  = 384,
    parameter int UV_TICKS       = 448,
    parameter int DEAD_TICKS     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [2*N_LEG+3:0]   cmd_in,
    input  logic                 cmd_wr,
    input  logic [N_LEG-1:0]     oc_flag,
    input  logic                 uv_flag,
    input  logic                 tp_flag,
    input  logic                 tsd_flag,
    input  logic [2*N_LEG-1:0]   ol_flag,
    input  logic                 inh_n,
    output logic [2*N_LEG-1:0]   sw_en,
    output logic [2*N_LEG+3:0]   status
);
    localparam int N_SW   = 2 * N_LEG;
    localparam int WORD_W = N_SW + 4;
    localparam int B_OLOFF = top_bit(N_LEG, OFS_OLOFF);
    localparam int B_LONG  = top_bit(N_LEG, OFS_LONG);
    localparam int B_RUN   = top_bit(N_LEG, OFS_RUN);
    localparam int S_SCD   = top_bit(N_LEG, OFS_SCD);
    localparam int S_INH   = top_bit(N_LEG, OFS_INH);
    localparam int S_PSF   = top_bit(N_LEG, OFS_PSF);
    localparam int MAX_SC  = (SC_LONG_TICKS > SC_SHORT_TICKS) ? SC_LONG_TICKS : SC_SHORT_TICKS;
    localparam int MAX_T   = (MAX_SC > UV_TICKS) ? MAX_SC : UV_TICKS;
    localparam int CNT_W   = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SC_SHORT_TICKS);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(SC_LONG_TICKS);
    localparam logic [CNT_W-1:0] LIM_UV    = CNT_W'(UV_TICKS);
    localparam logic [WORD_W-1:0] POR_WORD =
        (WORD_W'(1) << B_OLOFF) | (WORD_W'(1) << B_LONG) | (WORD_W'(1) << B_RUN);

    typedef struct packed {
        logic [WORD_W-1:1] ctrl;
        logic              hot;
    } top_t;

    top_t st_d, st_q;
    logic             clr, inhibit, allow, uv_block, pf;
    logic [CNT_W-1:0] sc_limit;
    logic [N_LEG-1:0] trip;
    logic [N_LEG-1:0] req_lo, req_hi;

    assign clr      = cmd_wr && cmd_in[POS_CLEAR];
    assign sc_limit = st_q.ctrl[B_LONG] ? LIM_LONG : LIM_SHORT;
    assign inhibit  = !st_q.ctrl[B_RUN] || !inh_n;
    assign allow    = !inhibit && !uv_block && !st_q.hot;

    always_comb begin
        st_d = st_q;
        if (cmd_wr) st_d.ctrl = cmd_in[WORD_W-1:1];
        if (tsd_flag) st_d.hot = 1'b1;
        else if (clr) st_d.hot = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctrl: POR_WORD[WORD_W-1:1], hot: 1'b0};
        else        st_q <= st_d;
    end

    hb_delay_timer #(.CNT_W(CNT_W)) uv_tmr_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(uv_flag), .clr(clr),
        .limit(LIM_UV), .done(uv_block), .flag(pf)
    );

    for (genvar k = 0; k < N_LEG; k++) begin : g_leg
        logic sc_done;
        hb_delay_timer #(.CNT_W(CNT_W)) sc_tmr_i (
            .clk(clk), .rst_n(rst_n), .tick(tick), .run(oc_flag[k]), .clr(clr),
            .limit(sc_limit), .done(sc_done), .flag(trip[k])
        );
        assign req_lo[k] = st_q.ctrl[SW_BASE + 2*k]     && allow && !trip[k];
        assign req_hi[k] = st_q.ctrl[SW_BASE + 2*k + 1] && allow && !trip[k];
        hb_leg_gate #(.DEAD_TICKS(DEAD_TICKS)) gate_i (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .req_lo(req_lo[k]), .req_hi(req_hi[k]),
            .en_lo(sw_en[2*k]), .en_hi(sw_en[2*k+1])
        );
    end

    always_comb begin
        status = '0;
        status[POS_PREWARN] = tp_flag;
        for (int j = 0; j < N_SW; j++) begin
            status[SW_BASE + j] = (!st_q.ctrl[B_OLOFF] && !st_q.ctrl[SW_BASE + j])
                                  ? ol_flag[j] : sw_en[j];
        end
        status[S_SCD] = |trip;
        status[S_INH] = inhibit;
        status[S_PSF] = pf;
        if (st_q.hot) status = '1;
    end

    // R8: thermal shutdown darkens every switch within two edges
    p_hot_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_flag |=> ##1 (sw_en == '0));
    // R11: either inhibit source darkens every switch at the next edge
    p_inhibit_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (sw_en == '0));
    // R7: an expired undervoltage darkens every switch at the next edge
    p_uv_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        uv_block |=> (sw_en == '0));
endmodule

// File: tb/hb_fault_ctrl_tb_top.sv
module hb_fault_ctrl_tb_top;
    localparam int TDIV = 4;
    localparam int SCS  = 3;
    localparam int SCL  = 8;
    localparam int UVT  = 5;
    localparam int DT   = 2;
    localparam logic [15:0] W_RUN  = 16'h8000;
    localparam logic [15:0] W_LONG = 16'h4000;
    localparam logic [15:0] W_OLOF = 16'h2000;
    localparam logic [15:0] W_CLR  = 16'h0001;
    localparam logic [15:0] BASE   = W_RUN | W_LONG | W_OLOF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] cmd_in = '0;
    logic        cmd_wr = 1'b0;
    logic [5:0]  oc_flag = '0;
    logic        uv_flag = 1'b0;
    logic        tp_flag = 1'b0;
    logic        tsd_flag = 1'b0;
    logic [11:0] ol_flag = '0;
    logic        inh_n = 1'b1;
    logic [11:0] sw_en;
    logic [15:0] status;

    int checks = 0;
    int errs   = 0;
    int tdiv   = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tdiv <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        tick <= (tdiv == TDIV - 1);
    end

    hb_fault_ctrl #(
        .N_LEG(6), .SC_SHORT_TICKS(SCS), .SC_LONG_TICKS(SCL),
        .UV_TICKS(UVT), .DEAD_TICKS(DT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_in(cmd_in), .cmd_wr(cmd_wr),
        .oc_flag(oc_flag), .uv_flag(uv_flag), .tp_flag(tp_flag), .tsd_flag(tsd_flag),
        .ol_flag(ol_flag), .inh_n(inh_n), .sw_en(sw_en), .status(status)
    );

    function automatic logic [15:0] ls(input int k); return 16'(1) << (2*k + 1); endfunction
    function automatic logic [15:0] hs(input int k); return 16'(1) << (2*k + 2); endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] w);
        @(negedge clk);
        cmd_in = w;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic settle();
        cyc(20);
    endtask

    initial begin
        logic [15:0] word, exp;
        cyc(3);
        rst_n = 1'b1;
        ol_flag = '1;
        cyc(2);
        // R1: reset state, open-load reporting off by default
        chk("R1 status after reset", status, 16'h0000);
        chk("R1 enables after reset", {4'h0, sw_en}, 16'h0000);
        ol_flag = '0;

        // R2: every single switch
        for (int j = 0; j < 12; j++) begin
            wr(BASE); settle();
            wr(BASE | (16'(1) << (j + 1))); cyc(2);
            chk("R2 single enable", {4'h0, sw_en}, 16'(1) << j);
            chk("R2 single status", status, 16'(1) << (j + 1));
        end

        // R3: four-state request mix across stages
        for (int v = 0; v < 4; v++) begin
            wr(BASE); settle();
            word = BASE; exp = '0;
            for (int k = 0; k < 6; k++) begin
                case ((v + k) % 4)
                    1: begin word |= ls(k); exp |= 16'(1) << (2*k); end
                    2: begin word |= hs(k); exp |= 16'(1) << (2*k + 1); end
                    3: word |= ls(k) | hs(k);
                    default: ;
                endcase
            end
            wr(word); cyc(2);
            chk("R3 mixed requests", {4'h0, sw_en}, exp);
        end

        // R4: dead time from high side to low side
        wr(BASE); settle();
        wr(BASE | hs(0)); cyc(2);
        chk("R4 high on", {4'h0, sw_en}, 16'h0002);
        wr(BASE | ls(0)); cyc(2);
        chk("R4 partner held off", {4'h0, sw_en}, 16'h0000);
        cyc(10);
        chk("R4 partner on after gap", {4'h0, sw_en}, 16'h0001);

        // R5 / R10: long delay
        wr(BASE); settle();
        wr(BASE | ls(0) | ls(1)); cyc(2);
        oc_flag[0] = 1'b1;
        cyc((SCL - 1) * TDIV);
        chk("R5 long delay not yet", {4'h0, sw_en}, 16'h0005);
        cyc(2 * TDIV + 2);
        chk("R5 long delay tripped", {4'h0, sw_en}, 16'h0004);
        chk("R5 long delay status", status, 16'h2008);
        oc_flag[0] = 1'b0;
        wr(BASE | ls(0) | ls(1) | W_CLR); cyc(2);
        chk("R10 clear re-enables", {4'h0, sw_en}, 16'h0005);
        chk("R10 clear status", status, 16'h000A);

        // R5: short delay
        word = W_RUN | W_OLOF | ls(0) | ls(1);
        wr(word); cyc(2);
        oc_flag[0] = 1'b1;
        cyc((SCS - 1) * TDIV);
        chk("R5 short delay not yet", {4'h0, sw_en}, 16'h0005);
        cyc(2 * TDIV + 2);
        chk("R5 short delay tripped", {4'h0, sw_en}, 16'h0004);
        oc_flag[0] = 1'b0;
        wr(word | W_CLR); cyc(2);
        chk("R10 clear after short", status, 16'h000A);

        // R6: repeated brief overcurrent never accumulates
        for (int p = 0; p < 3; p++) begin
            oc_flag[0] = 1'b1; cyc(6);
            oc_flag[0] = 1'b0; cyc(2);
        end
        cyc(20);
        chk("R6 no trip from brief pulses", status, 16'h000A);

        // R7: undervoltage
        wr(BASE | ls(0)); cyc(2);
        uv_flag = 1'b1;
        cyc((UVT - 1) * TDIV);
        chk("R7 uv not yet", {4'h0, sw_en}, 16'h0001);
        cyc(2 * TDIV + 2);
        chk("R7 uv shutdown", {4'h0, sw_en}, 16'h0000);
        chk("R7 uv status", status, 16'h8000);
        uv_flag = 1'b0; cyc(3);
        chk("R7 uv recovers at once", {4'h0, sw_en}, 16'h0001);
        chk("R7 flag held", status, 16'h8002);
        wr(BASE | ls(0) | W_CLR); cyc(2);
        chk("R10 clear supply flag", status, 16'h0002);

        // R8: thermal shutdown
        tsd_flag = 1'b1; cyc(3);
        chk("R8 all ones", status, 16'hFFFF);
        chk("R8 dark", {4'h0, sw_en}, 16'h0000);
        wr(BASE | ls(0) | W_CLR); cyc(3);
        chk("R8 clear while hot ignored", status, 16'hFFFF);
        chk("R8 still dark", {4'h0, sw_en}, 16'h0000);
        tsd_flag = 1'b0; cyc(3);
        chk("R8 cooled but not cleared", status, 16'hFFFF);
        wr(BASE | ls(0) | W_CLR); cyc(2);
        chk("R8 recovered status", status, 16'h0002);
        chk("R8 recovered enable", {4'h0, sw_en}, 16'h0001);

        // R9: prewarning follows the flag
        tp_flag = 1'b1; cyc(1);
        chk("R9 prewarn high", status, 16'h0003);
        tp_flag = 1'b0; cyc(1);
        chk("R9 prewarn low", status, 16'h0002);

        // R11: both inhibit sources
        wr(W_LONG | W_OLOF | ls(0)); cyc(2);
        chk("R11 soft inhibit", {4'h0, sw_en}, 16'h0000);
        chk("R11 soft inhibit status", status, 16'h4000);
        wr(BASE | ls(0)); cyc(2);
        chk("R11 command kept during inhibit", {4'h0, sw_en}, 16'h0001);
        inh_n = 1'b0; cyc(2);
        chk("R11 pin inhibit", {4'h0, sw_en}, 16'h0000);
        chk("R11 pin inhibit status", status, 16'h4000);
        inh_n = 1'b1; cyc(2);
        chk("R11 pin released", status, 16'h0002);

        // R12: open-load reporting
        wr(W_RUN | W_LONG | ls(0)); cyc(2);
        for (int q = 0; q < 3; q++) begin
            ol_flag = (q == 0) ? 12'hFFE : (q == 1) ? 12'h555 : 12'hAAA;
            cyc(1);
            exp = 16'h0002;
            for (int j = 1; j < 12; j++) exp[j + 1] = ol_flag[j];
            chk("R12 open-load status", status, exp);
        end
        chk("R12 requested switch stays on", {4'h0, sw_en}, 16'h0001);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule